// File: doc/BRIEF.md
# SPI Transmit Character Unpacker

This block sits between a 32-bit processor write port and the data line of an SPI master. Software writes a word carrying one to four byte lanes; the enabled lanes go into a byte-wide transmit FIFO in lane order. A shifter then takes characters of 4 to 16 bits out of the FIFO and drives them bit by bit onto the serial output, one bit for each clock-enable strobe. The shifter only transmits and has no receive path, so a transmit-only half-duplex phase needs no special handling.

Characters of up to 8 bits use one byte each. Wider characters use two consecutive bytes. Normally the low byte comes first and the upper bits sit right-aligned in the second byte. For full 16-bit characters sent msb first, the two bytes of a pair are swapped. A character starts shifting only when all of its bytes are in the FIFO. A write that needs more bytes than the FIFO has free is dropped whole and sets a sticky overflow flag.

The length field and the reverse control are expected to stay constant while the FIFO holds data.

Top module: `spi_txu_top`

## Requirements
- R1: After reset `sdo_o`=0, `tx_active_o`=0, `tx_not_full_o`=1 and `ovf_o`=0.
- R2: `char_len_i` holds the character length minus one. Valid values are 3 to 15, giving 4 to 16 bits.
- R3: For lengths 4 to 8, each byte carries one character in its low bits, with the lsb at bit 0 of the byte. The byte bits above the length are ignored.
- R4: Lane 0 is `wr_data_i[31:24]` and is enabled by `wr_be_i[3]`. Lanes 1, 2 and 3 are bits [23:16], [15:8] and [7:0], enabled by `wr_be_i[2]`, `wr_be_i[1]` and `wr_be_i[0]`. The enabled lanes enter the FIFO in lane order, so a 1- or 2-byte write fills the FIFO from lane 0 onward.
- R5: For lengths 9 to 16, with reverse off (or a length below 16), the first byte gives character bits [7:0]. The low (length-8) bits of the second byte give the upper bits. The other bits of the second byte are ignored.
- R6: For length 16 with `rev_i`=1, the first byte of the pair is character bits [15:8] and the second byte is bits [7:0].
- R7: With `rev_i`=0 the character leaves lsb first. With `rev_i`=1 it leaves msb first. Example: a length of 11 with bytes 0xFB then 0x05 is sent as 1,1,0,1,1,1,1,1,1,0,1.
- R8: The output changes only on a cycle with `sclk_en_i` high, and each bit is held for one strobe interval. A character starts only on a strobe and only when all of its bytes are present. Characters follow each other with no gap while data is available.
- R9: `tx_not_full_o` is 1 exactly when the FIFO (16 bytes by default) holds fewer bytes than its depth.
- R10: A write whose enabled-byte count exceeds the free space stores no byte and sets `ovf_o`. `ovf_o` stays set until reset.
- R11: When no character is being shifted, `tx_active_o`=0 and `sdo_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the data word |
| wr_data_i | input | 32 | Write data, lane 0 in bits [31:24] |
| wr_be_i | input | 4 | Lane enables, bit 3 for lane 0 |
| char_len_i | input | 4 | Character length minus one |
| rev_i | input | 1 | 1: msb first, and byte swap at length 16 |
| sclk_en_i | input | 1 | Serial clock-enable strobe |
| sdo_o | output | 1 | Serial data out |
| tx_active_o | output | 1 | A character is on the line |
| tx_not_full_o | output | 1 | FIFO has at least one free byte |
| ovf_o | output | 1 | Sticky dropped-write flag |

## Verification
The bench targets the cases that depend on byte layout. It uses the 11-bit example: a design that took the upper bits from the wrong end of the second byte would send a different tail. It uses 16-bit pairs with reverse on and off: a missing swap sends the bytes in the wrong order. It uses narrow characters with junk in the upper byte bits, which a design that failed to mask would put on the line. A lone first byte of a wide character is written and held: a design that started early would assert `tx_active_o`. A 2-byte write into a FIFO with one free byte must disappear completely, and a design that stored part of it would add extra characters to the stream.

// File: rtl/spi_txu_pkg.sv
package spi_txu_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int CHAR_W = 16;
  localparam int LEN_W  = $clog2(CHAR_W + 1);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/spi_txu_fifo.sv
module spi_txu_fifo
  import spi_txu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [LANES*BYTE_W-1:0] wr_data_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [1:0]              pop_n_i,
  output byte_t                   head0_o,
  output byte_t                   head1_o,
  output logic [CW-1:0]           count_o,
  output logic                    ovf_o
);
  byte_t          mem [DEPTH];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  count_q, free;
  logic [NW-1:0]  off [LANES];
  logic [NW-1:0]  push_n;
  logic           push_ok, push_bad;

  // slot offset of each enabled lane, packed in lane order
  always_comb begin
    push_n = '0;
    for (int k = 0; k < LANES; k++) begin
      off[k] = push_n;
      if (wr_be_i[LANES-1-k]) push_n = push_n + NW'(1);
    end
  end

  assign free     = CW'(DEPTH) - count_q;
  assign push_ok  = wr_en_i && (push_n != '0) && (CW'(push_n) <= free);
  assign push_bad = wr_en_i && (CW'(push_n) > free);

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      for (int k = 0; k < LANES; k++) begin
        if (wr_be_i[LANES-1-k])
          mem[wr_ptr_q + AW'(off[k])] <= wr_data_i[(LANES-1-k)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(push_n);
      rd_ptr_q <= rd_ptr_q + AW'(pop_n_i);
      count_q  <= count_q + (push_ok ? CW'(push_n) : CW'(0)) - CW'(pop_n_i);
      if (push_bad) ovf_o <= 1'b1;
    end
  end

  assign head0_o = mem[rd_ptr_q];
  assign head1_o = mem[rd_ptr_q + AW'(1)];
  assign count_o = count_q;
endmodule

// File: rtl/spi_txu_assemble.sv
module spi_txu_assemble
  import spi_txu_pkg::*;
(
  input  byte_t            b0_i,
  input  byte_t            b1_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rev_i,
  output char_t            char_o
);
  logic [CHAR_W:0] mask_full;
  char_t           mask;

  assign mask_full = ((CHAR_W+1)'(1) << len_i) - (CHAR_W+1)'(1);
  assign mask      = mask_full[CHAR_W-1:0];

  always_comb begin
    if (len_i <= LEN_W'(BYTE_W))
      char_o = {{(CHAR_W-BYTE_W){1'b0}}, b0_i} & mask;
    else if (rev_i && len_i == LEN_W'(CHAR_W))
      char_o = {b0_i, b1_i};  // high byte first for full-width msb-first
    else
      char_o = {b1_i, b0_i} & mask;
  end
endmodule

// File: rtl/spi_txu_shifter.sv
module spi_txu_shifter
  import spi_txu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_en_i,
  input  logic             avail_i,
  input  char_t            char_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rev_i,
  output logic             load_o,
  output logic             sdo_o,
  output logic             active_o
);
  char_t            sr_q, aligned;
  logic [LEN_W-1:0] left_q;
  logic             active_q, rev_q;

  assign load_o  = sclk_en_i && avail_i && (!active_q || left_q == '0);
  assign aligned = rev_i ? char_i << (LEN_W'(CHAR_W) - len_i) : char_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
      rev_q    <= 1'b0;
    end else if (sclk_en_i) begin
      if (load_o) begin
        sr_q     <= aligned;
        left_q   <= len_i - LEN_W'(1);
        active_q <= 1'b1;
        rev_q    <= rev_i;
      end else if (active_q && left_q != '0) begin
        sr_q   <= rev_q ? sr_q << 1 : sr_q >> 1;
        left_q <= left_q - LEN_W'(1);
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  assign sdo_o    = active_q && (rev_q ? sr_q[CHAR_W-1] : sr_q[0]);
  assign active_o = active_q;
endmodule

// File: rtl/spi_txu_top.sv
module spi_txu_top
  import spi_txu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [LANES*BYTE_W-1:0] wr_data_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [LEN_W-2:0]        char_len_i,
  input  logic                    rev_i,
  input  logic                    sclk_en_i,
  output logic                    sdo_o,
  output logic                    tx_active_o,
  output logic                    tx_not_full_o,
  output logic                    ovf_o
);
  byte_t            head0, head1;
  char_t            char_w;
  logic [CW-1:0]    count;
  logic [LEN_W-1:0] len;
  logic [1:0]       need, pop_n;
  logic             avail, load;

  assign len   = {1'b0, char_len_i} + LEN_W'(1);
  assign need  = (len > LEN_W'(BYTE_W)) ? 2'd2 : 2'd1;
  assign avail = count >= CW'(need);
  assign pop_n = load ? need : 2'd0;

  spi_txu_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_be_i   (wr_be_i),
    .pop_n_i   (pop_n),
    .head0_o   (head0),
    .head1_o   (head1),
    .count_o   (count),
    .ovf_o     (ovf_o)
  );

  spi_txu_assemble u_asm (
    .b0_i   (head0),
    .b1_i   (head1),
    .len_i  (len),
    .rev_i  (rev_i),
    .char_o (char_w)
  );

  spi_txu_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_en_i (sclk_en_i),
    .avail_i   (avail),
    .char_i    (char_w),
    .len_i     (len),
    .rev_i     (rev_i),
    .load_o    (load),
    .sdo_o     (sdo_o),
    .active_o  (tx_active_o)
  );

  assign tx_not_full_o = count < CW'(DEPTH);
endmodule

// File: rtl/spi_txu_chk.sv
module spi_txu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [3:0] wr_be_i,
  input logic [3:0] char_len_i,
  input logic       sclk_en_i,
  input logic       sdo_o,
  input logic       tx_active_o,
  input logic       tx_not_full_o,
  input logic       ovf_o
);
  a_r2_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> char_len_i >= 4'd3);

  a_r8_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_en_i |=> $stable(sdo_o) && $stable(tx_active_o));

  a_r8_start_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> $past(sclk_en_i));

  a_r10_full_write_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i != 4'd0 && !tx_not_full_o) |=> ovf_o);

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r11_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> !sdo_o);
endmodule

bind spi_txu_top spi_txu_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_be_i       (wr_be_i),
  .char_len_i    (char_len_i),
  .sclk_en_i     (sclk_en_i),
  .sdo_o         (sdo_o),
  .tx_active_o   (tx_active_o),
  .tx_not_full_o (tx_not_full_o),
  .ovf_o         (ovf_o)
);

// File: tb/sim_spi_txu_top.sv
module sim_spi_txu_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [3:0]  char_len = 4'd7;
  logic        rev = 1'b0;
  logic        sclk_en = 1'b0;
  logic        sdo, tx_active, tx_not_full, ovf;

  int total = 0;
  int bad = 0;
  bit strobe_on = 1'b0;
  bit en_prev = 1'b0;
  bit phase = 1'b0;
  logic       exp_q[$];
  string      tag_q[$];
  logic [7:0] mq[$];
  int  cfg_len = 8;
  bit  cfg_rev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_txu_top #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_be_i(wr_be), .char_len_i(char_len), .rev_i(rev), .sclk_en_i(sclk_en),
    .sdo_o(sdo), .tx_active_o(tx_active), .tx_not_full_o(tx_not_full), .ovf_o(ovf)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // character from its byte(s), written from R3, R5, R6
  function automatic logic [15:0] make_char(logic [7:0] b0, logic [7:0] b1, int len, bit rv);
    logic [15:0] c;
    if (len <= 8) begin
      c = 16'(b0);
      for (int i = len; i < 16; i++) c[i] = 1'b0;
    end else if (rv && len == 16) begin
      c = {b0, b1};
    end else begin
      c = {b1, b0};
      for (int i = len; i < 16; i++) c[i] = 1'b0;
    end
    return c;
  endfunction

  task automatic model_byte(logic [7:0] b, string tag);
    int need;
    logic [15:0] c;
    logic [7:0] b0, b1;
    mq.push_back(b);
    need = (cfg_len > 8) ? 2 : 1;
    while (mq.size() >= need) begin
      b0 = mq.pop_front();
      b1 = (need == 2) ? mq.pop_front() : 8'h00;
      c = make_char(b0, b1, cfg_len, cfg_rev);
      for (int i = 0; i < cfg_len; i++) begin  // R7 bit order
        exp_q.push_back(cfg_rev ? c[cfg_len-1-i] : c[i]);
        tag_q.push_back(tag);
      end
    end
  endtask

  // R4: lane k is data[31-8k -: 8], enabled by be[3-k]
  task automatic wr(logic [31:0] d, logic [3:0] be, bit accept, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    if (accept)
      for (int k = 0; k < 4; k++)
        if (be[3-k]) model_byte(d[31-8*k -: 8], tag);
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic set_cfg(int len, bit rv);
    cfg_len = len; cfg_rev = rv;
    char_len = 4'(len - 1); rev = rv;  // R2
  endtask

  task automatic drain(string tag);
    int n = 0;
    while ((exp_q.size() != 0 || tx_active) && n < 5000) begin
      @(negedge clk); n++;
    end
    check(exp_q.size() == 0 && !tx_active, tag, exp_q.size(), 0);
  endtask

  // strobe driver and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && en_prev && tx_active) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8_extra_bit", 1, 0);
        end else begin
          logic e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(sdo == e, t, int'(sdo), int'(e));
        end
      end
      phase = ~phase;
      sclk_en = strobe_on && phase;
      en_prev = sclk_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sdo == 1'b0, "R1_sdo", int'(sdo), 0);
    check(tx_active == 1'b0, "R1_active", int'(tx_active), 0);
    check(tx_not_full == 1'b1, "R1_not_full", int'(tx_not_full), 1);
    check(ovf == 1'b0, "R1_ovf", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    strobe_on = 1'b1;

    // R3 R7 8-bit lsb first, full words
    set_cfg(8, 0);
    wr(32'hA5_3C_01_F0, 4'b1111, 1, "R3_len8");
    wr(32'h12_34_56_78, 4'b1111, 1, "R3_len8");
    drain("R8_drain_len8");

    // R3 5-bit with junk upper bits, R4 2-byte and 1-byte writes
    set_cfg(5, 0);
    wr(32'hFF_E1_37_A5, 4'b1111, 1, "R3_len5_mask");
    wr(32'h9B_C4_00_00, 4'b1100, 1, "R4_two_lanes");
    wr(32'h6D_FF_FF_FF, 4'b1000, 1, "R4_one_lane");
    drain("R8_drain_len5");

    // R7 4-bit msb first
    set_cfg(4, 1);
    wr(32'h3A_F5_0C_B9, 4'b1111, 1, "R7_len4_msb");
    drain("R8_drain_len4");

    // R5 R7 11-bit example: 0xFB,0x05 -> 1,1,0,1,1,1,1,1,1,0,1
    set_cfg(11, 0);
    wr(32'hFB_05_00_00, 4'b1100, 1, "R7_example_len11");
    wr(32'h2C_FE_81_03, 4'b1111, 1, "R5_len11_mask");
    drain("R8_drain_len11");

    // R6 16-bit msb first byte swap; R5 16-bit lsb first
    set_cfg(16, 1);
    wr(32'hC3_5A_01_80, 4'b1111, 1, "R6_len16_swap");
    drain("R8_drain_r6");
    set_cfg(16, 0);
    wr(32'hC3_5A_01_80, 4'b1111, 1, "R5_len16_lsb");
    drain("R8_drain_r5");

    // R5 R7 12-bit msb first, no swap
    set_cfg(12, 1);
    wr(32'h96_F7_4E_A2, 4'b1111, 1, "R5_len12_msb");
    drain("R8_drain_len12");

    // R8 wide char waits for its second byte
    set_cfg(16, 0);
    wr(32'h81_00_00_00, 4'b1000, 1, "R8_partial");
    repeat (20) @(negedge clk);
    check(tx_active == 1'b0, "R8_no_early_start", int'(tx_active), 0);
    check(sdo == 1'b0, "R11_idle_sdo", int'(sdo), 0);
    wr(32'h7E_00_00_00, 4'b1000, 1, "R8_partial");
    drain("R8_drain_partial");

    // R9 R10 fill with strobes stopped
    set_cfg(8, 0);
    strobe_on = 1'b0;
    repeat (4) @(negedge clk);
    wr(32'h01_02_03_04, 4'b1111, 1, "R10_kept");
    wr(32'h05_06_07_08, 4'b1111, 1, "R10_kept");
    wr(32'h09_0A_0B_0C, 4'b1111, 1, "R10_kept");
    wr(32'h0D_0E_0F_00, 4'b1110, 1, "R10_kept");
    check(tx_not_full == 1'b1, "R9_fifteen", int'(tx_not_full), 1);
    check(ovf == 1'b0, "R10_no_ovf_yet", int'(ovf), 0);
    wr(32'hEE_DD_00_00, 4'b1100, 0, "R10_dropped");
    check(ovf == 1'b1, "R10_ovf_set", int'(ovf), 1);
    check(tx_not_full == 1'b1, "R10_nothing_stored", int'(tx_not_full), 1);
    wr(32'h5F_00_00_00, 4'b1000, 1, "R10_last_byte");
    check(tx_not_full == 1'b0, "R9_full", int'(tx_not_full), 0);
    wr(32'h11_22_33_44, 4'b1111, 0, "R10_dropped_full");
    strobe_on = 1'b1;
    drain("R10_drain");
    check(ovf == 1'b1, "R10_sticky", int'(ovf), 1);
    check(tx_not_full == 1'b1, "R9_empty_again", int'(tx_not_full), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule